// File: doc/BRIEF.md
# Burst Address Generator

This block produces the full address for each beat of a four-beat burst. A controller gives it a load pulse when an access starts and an advance pulse for each later beat. On a load, the block captures the whole incoming address. The upper bits are held unchanged for the rest of the burst. The two low bits become the start value of a 2-bit beat counter.

The counter keeps a beat offset `k`, which starts at zero. The low address bits are formed from the latched start value and `k`. An order-select input chooses how they are formed. In the interleaved order the low bits are the start XOR `k`. In the linear order they are the start plus `k`, wrapped within the group of four. Both orders begin at any start position within the group. The order select is registered, so a change reaches the output one cycle after it is applied.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `beatAddr` is all zeros and the latched order is linear.
- R2: When `loadPulse` is high at a rising edge, `beatAddr` equals `addrIn` from that edge onward. This is beat 0, with offset k = 0.
- R3: With the latched order linear (`orderSel` = 0), the low two bits of `beatAddr` for beat k are (start + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R4: With the latched order interleaved (`orderSel` = 1), the low two bits for beat k are start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R5: A rising edge with both `advPulse` and `loadPulse` low leaves `beatAddr` unchanged, unless the latched order changes at that edge.
- R6: When `loadPulse` and `advPulse` are both high at the same edge, the load wins. The output becomes the new `addrIn` at beat 0.
- R7: An advance after the fourth beat (k = 3) wraps back to beat 0 of the same group, which is the start value.
- R8: The output uses the value of `orderSel` sampled at the previous rising edge. A change of `orderSel` between edges does not alter `beatAddr` until the next edge.
- R9: The upper `ADDR_W-2` bits of `beatAddr` stay equal to those captured at the load, for every beat and wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| loadPulse | input | 1 | Start of access: capture `addrIn` and reset the beat offset |
| advPulse | input | 1 | Step to the next beat of the burst |
| orderSel | input | 1 | Beat order: 1 = interleaved (XOR), 0 = linear (wrapping add) |
| addrIn | input | ADDR_W | Access start address |
| beatAddr | output | ADDR_W | Address of the current beat |

## Verification
A corrupted beat offset or latched start value shows up at the low two bits of `beatAddr` immediately after the edge that stores it. The error then stays visible on every later beat of the burst, so checking each beat right after its edge catches it within one cycle. A wrong latched order looks identical to the right one at beat 0 and on some later beats. It can therefore only be told apart on beats where the two orders differ, such as start 01 at k = 1. A corrupted upper register shows on every beat until the next load.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture address, clear offset
    logic adv;    // step offset (never together with load)
  } burstStrb_t;

  // Beat low bits from start value, offset and order
  function automatic logic [1:0] beatBits(input logic [1:0] startVal,
                                          input logic [1:0] offs,
                                          input logic interleave);
    beatBits = interleave ? (startVal ^ offs) : (startVal + offs);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadPulse,
  input  logic       advPulse,
  input  logic       orderSel,
  output burstStrb_t strb,
  output logic       orderQ
);

  // Load has priority over advance
  always_comb begin
    strb.load = loadPulse;
    strb.adv  = advPulse & ~loadPulse;
  end

  // Order select takes effect one cycle later
  always_ff @(posedge clk) begin
    if (rst) orderQ <= 1'b0;
    else     orderQ <= orderSel;
  end

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    loadPulse |-> !strb.adv);

  // R8
  order_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (orderSel != orderQ) |=> (orderQ == $past(orderSel)));

endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  burstStrb_t        strb,
  input  logic              orderQ,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] beatAddr
);

  localparam int UP_W = ADDR_W - 2;

  logic [UP_W-1:0] upperQ;
  logic [1:0]      startQ;
  logic [1:0]      offsQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      upperQ <= '0;
      startQ <= '0;
      offsQ  <= '0;
    end else if (strb.load) begin
      upperQ <= addrIn[ADDR_W-1:2];
      startQ <= addrIn[1:0];
      offsQ  <= '0;
    end else if (strb.adv) begin
      offsQ  <= offsQ + 2'd1;   // wraps 3 -> 0
    end
  end

  assign beatAddr = {upperQ, beatBits(startQ, offsQ, orderQ)};

  // R2
  load_beat0_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (beatAddr == $past(addrIn)));

  // R7
  adv_step_chk: assert property (@(posedge clk) disable iff (rst)
    strb.adv |=> (offsQ == 2'($past(offsQ) + 2'd1)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.adv) |=> $stable(offsQ) && $stable(startQ));

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(beatAddr[ADDR_W-1:2]));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadPulse,
  input  logic              advPulse,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] beatAddr
);

  burstStrb_t strb;
  logic       orderQ;

  burst_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .loadPulse (loadPulse),
    .advPulse  (advPulse),
    .orderSel  (orderSel),
    .strb      (strb),
    .orderQ    (orderQ)
  );

  burst_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .orderQ   (orderQ),
    .addrIn   (addrIn),
    .beatAddr (beatAddr)
  );

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              loadPulse = 1'b0;
  logic              advPulse = 1'b0;
  logic              orderSel = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] beatAddr;

  int vecCnt = 0;
  int errCnt = 0;

  always #4 clk = ~clk;   // 125 MHz

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .loadPulse(loadPulse), .advPulse(advPulse),
    .orderSel(orderSel), .addrIn(addrIn), .beatAddr(beatAddr)
  );

  function automatic logic [1:0] expLow(input logic [1:0] s, input logic [1:0] k,
                                        input logic il);
    return il ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    vecCnt++;
    if (beatAddr !== exp) begin
      errCnt++;
      $display("FAIL %s: beatAddr=%h expected=%h", req, beatAddr, exp);
    end
  endtask

  // Apply inputs at negedge, clock one edge, return at next negedge
  task automatic tick(input logic ld, input logic adv, input logic [ADDR_W-1:0] a);
    loadPulse = ld; advPulse = adv; addrIn = a;
    @(posedge clk);
    @(negedge clk);
    loadPulse = 1'b0; advPulse = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(1'b0, 1'b0, '0);
    rst = 1'b0;
    check("R1 reset", '0);
  endtask

  task automatic t_burst(input logic il, input logic [ADDR_W-1:0] a, input string req);
    orderSel = il;
    tick(1'b1, 1'b0, a);
    check("R2 load", a);
    for (int k = 1; k < 4; k++) begin
      tick(1'b0, 1'b1, '0);
      check(req, {a[ADDR_W-1:2], expLow(a[1:0], 2'(k), il)});
    end
    tick(1'b0, 1'b1, '0);
    check("R7 wrap", a);
    tick(1'b0, 1'b1, '0);
    check("R9 upper", {a[ADDR_W-1:2], expLow(a[1:0], 2'd1, il)});
  endtask

  task automatic t_hold();
    orderSel = 1'b0;
    tick(1'b1, 1'b0, 17'h0F0F2);
    tick(1'b0, 1'b1, '0);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0, 17'h1FFFF);
      check("R5 hold", 17'h0F0F3);
    end
  endtask

  task automatic t_loadWins();
    orderSel = 1'b1;
    tick(1'b1, 1'b0, 17'h12341);
    tick(1'b0, 1'b1, '0);
    check("R4 interleave", 17'h12340);
    tick(1'b1, 1'b1, 17'h05556);
    check("R6 load wins", 17'h05556);
    tick(1'b0, 1'b1, '0);
    check("R6 then step", 17'h05557);
  endtask

  task automatic t_orderLatency();
    orderSel = 1'b0;
    tick(1'b1, 1'b0, 17'h00AA1);
    tick(1'b0, 1'b1, '0);
    check("R3 linear", 17'h00AA2);
    orderSel = 1'b1;
    #1;
    check("R8 before edge", 17'h00AA2);
    @(negedge clk);
    tick(1'b0, 1'b0, '0);
    check("R8 after edge", 17'h00AA0);
    orderSel = 1'b0;
    tick(1'b0, 1'b0, '0);
    check("R8 back", 17'h00AA2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_burst(1'b0, 17'h1ABCD, "R3 linear");
    t_burst(1'b1, 17'h1ABCD, "R4 interleave");
    t_burst(1'b1, 17'h0C3A6, "R4 interleave");
    t_burst(1'b0, 17'h0C3A7, "R3 linear");
    t_hold();
    t_loadWins();
    t_orderLatency();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule